// File: doc/BRIEF.md
# DRAM refresh request scheduler

This block converts a slow periodic trigger, typically a timer or baud-rate output wired back to an input pin, into DRAM refresh bus cycles. It synchronizes the trigger pin and watches it for high-to-low transitions. Each transition latches one pending refresh request. The block then arbitrates that request against host command requests and serial-channel service requests, and refresh always wins.

A granted refresh occupies the scheduler for a fixed service window of 25 clocks. Inside that window it issues one byte-wide read cycle on a simple asynchronous bus master port: address, strobe and read/write, ended by an acknowledge. The address comes from a counter that advances after each acknowledged cycle and wraps from a programmable limit back to a programmable base. A refresh never starts while a bus exception (reset, halt or bus error) is flagged, and the request waits until the exception clears.

Row and column strobes and address multiplexing are not produced here. External logic derives them from the plain read cycle.

Top module: `refresh_sched`

## Requirements
- R1: A high-to-low transition on `trig_in` (seen after a two-flop synchronizer, pin idle level high) creates exactly one refresh service. Rising edges and steady levels create none.
- R2: While a refresh is pending and no bus exception is flagged, no command or serial grant is given. A command request beats any serial request. Among serial requests the lowest index wins. At most one grant is active in any cycle. Grants are combinational one-cycle indications while the scheduler is idle.
- R3: No refresh service starts in a cycle in which `bus_exc` is high. The pending request is kept and starts once `bus_exc` is low.
- R4: A refresh service starts its bus cycle in its first service cycle. `bus_strb` and `bus_rw` (1 = read) stay high until a cycle in which `bus_ack` is sampled high, and the strobe is high only inside a service window.
- R5: A refresh service keeps `ref_busy` high for exactly 25 consecutive cycles. No command or serial grant is given while `ref_busy` is high.
- R6: `bus_addr` increments by one after each acknowledged refresh read. When it equals the limit, it returns to the base instead. A `cfg_load` pulse sets the base, sets the limit and sets `bus_addr` to the base, and it takes precedence over an acknowledge in the same cycle. Reset values are base 0 and limit all-ones.
- R7: A falling edge detected while a refresh is pending or in service is dropped and sets the sticky `overrun` flag. Only `cfg_load` clears the flag, and `cfg_load` wins over a simultaneous new overrun.
- R8: If no acknowledge arrives in 16 strobe cycles, `bus_abort` pulses in the 16th cycle and the strobe drops in the next cycle. The address is not advanced. The service window still runs its full length.
- R9: After reset `bus_addr` is 0, and `bus_strb`, `bus_rw`, `bus_abort`, `ref_busy`, `overrun` and all grants are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| trig_in | input | 1 | Asynchronous refresh trigger pin, falling edge requests a refresh |
| bus_exc | input | 1 | Bus exception active (reset, halt or bus error) |
| ser_req | input | NSER (3) | Serial-channel service requests |
| cmd_req | input | 1 | Host command request |
| cfg_load | input | 1 | Load base and limit and reset the address to base |
| cfg_base | input | AW (16) | Refresh address base |
| cfg_limit | input | AW (16) | Refresh address wrap limit |
| bus_ack | input | 1 | Bus cycle acknowledge |
| bus_addr | output | AW (16) | Refresh read address |
| bus_strb | output | 1 | Address/data strobe of the refresh read |
| bus_rw | output | 1 | Read indication, high during the refresh read |
| bus_abort | output | 1 | One-cycle pulse when the read times out |
| ser_gnt | output | NSER (3) | One-hot serial-channel grant |
| cmd_gnt | output | 1 | Command grant |
| ref_busy | output | 1 | Refresh service window active |
| overrun | output | 1 | Sticky dropped-trigger flag |

## Verification
Two collisions matter most. The first is a new trigger edge detected in the same cycle in which a service starts or ends, which decides between a new pending request and an overrun. The bench sweeps the spacing between trigger edges through the end of a service window so that the edge lands on each cycle around the boundary. The second is an acknowledge that arrives in the same cycle as a configuration load: the bench raises `cfg_load` exactly when it drives `bus_ack`, and the address must then equal the newly loaded base rather than the incremented value. In both cases the bench's behavioural model predicts every output on every cycle, and explicit checks confirm the resulting address and flag.

// File: rtl/refsch_pkg.sv
package refsch_pkg;
  typedef enum logic [1:0] {
    GNT_NONE = 2'd0,
    GNT_REF  = 2'd1,
    GNT_CMD  = 2'd2,
    GNT_SER  = 2'd3
  } gnt_kind_e;
endpackage

// File: rtl/refsch_sync_edge.sv
module refsch_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic fall
);
  localparam int DEPTH = STAGES + 1;
  logic [DEPTH-1:0] q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    logic d;
    if (g == 0) begin : g_first
      assign d = pin;
    end else begin : g_rest
      assign d = q[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[g] <= 1'b1;
      else        q[g] <= d;
    end
  end

  assign fall = q[DEPTH-1] & ~q[DEPTH-2];
endmodule

// File: rtl/refsch_arb.sv
module refsch_arb
  import refsch_pkg::*;
#(
  parameter int NSER = 3
) (
  input  logic            en,
  input  logic            ref_req,
  input  logic            cmd_req,
  input  logic [NSER-1:0] ser_req,
  output logic            ref_go,
  output logic            cmd_gnt,
  output logic [NSER-1:0] ser_gnt
);
  gnt_kind_e       kind;
  logic [NSER-1:0] ser_pick;
  logic            found;

  always_comb begin
    kind = GNT_NONE;
    if (en) begin
      if (ref_req)      kind = GNT_REF;
      else if (cmd_req) kind = GNT_CMD;
      else if (|ser_req) kind = GNT_SER;
    end
  end

  always_comb begin
    ser_pick = '0;
    found    = 1'b0;
    for (int i = 0; i < NSER; i++) begin
      if (ser_req[i] && !found) begin
        ser_pick[i] = 1'b1;
        found       = 1'b1;
      end
    end
  end

  assign ref_go  = (kind == GNT_REF);
  assign cmd_gnt = (kind == GNT_CMD);
  assign ser_gnt = (kind == GNT_SER) ? ser_pick : '0;
endmodule

// File: rtl/refsch_seq.sv
module refsch_seq #(
  parameter int SVC_CYC = 25,
  parameter int TMO_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic ack,
  output logic busy,
  output logic strb,
  output logic ack_done,
  output logic abort
);
  localparam int CW = $clog2(SVC_CYC);
  localparam int WW = $clog2(TMO_CYC);
  localparam logic [CW-1:0] CNT_LAST = CW'(SVC_CYC - 1);
  localparam logic [WW-1:0] WAIT_LAST = WW'(TMO_CYC - 1);

  logic          busy_q, busy_d;
  logic          strb_q, strb_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [WW-1:0] wcnt_q, wcnt_d;
  logic          cnt_en, wcnt_en;

  assign ack_done = strb_q & ack;
  assign abort    = strb_q & ~ack & (wcnt_q == WAIT_LAST);

  always_comb begin
    busy_d  = busy_q;
    strb_d  = strb_q;
    cnt_d   = cnt_q;
    wcnt_d  = wcnt_q;
    cnt_en  = 1'b0;
    wcnt_en = 1'b0;
    if (start) begin
      busy_d  = 1'b1;
      strb_d  = 1'b1;
      cnt_d   = '0;
      wcnt_d  = '0;
      cnt_en  = 1'b1;
      wcnt_en = 1'b1;
    end else begin
      if (busy_q) begin
        cnt_en = 1'b1;
        if (cnt_q == CNT_LAST) busy_d = 1'b0;
        else                   cnt_d  = cnt_q + 1'b1;
      end
      if (strb_q) begin
        wcnt_en = 1'b1;
        if (ack_done || abort) strb_d = 1'b0;
        else                   wcnt_d = wcnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      strb_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      strb_q <= strb_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wcnt_q <= '0;
    else if (wcnt_en) wcnt_q <= wcnt_d;
  end

  assign busy = busy_q;
  assign strb = strb_q;
endmodule

// File: rtl/refsch_addr.sv
module refsch_addr #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] base_in,
  input  logic [AW-1:0] lim_in,
  input  logic          adv,
  output logic [AW-1:0] addr
);
  logic [AW-1:0] addr_q, addr_d;
  logic [AW-1:0] base_q, lim_q;
  logic          addr_en;

  always_comb begin
    addr_en = load | adv;
    if (load)                 addr_d = base_in;
    else if (addr_q == lim_q) addr_d = base_q;
    else                      addr_d = addr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      lim_q  <= '1;
    end else if (load) begin
      base_q <= base_in;
      lim_q  <= lim_in;
    end
  end

  assign addr = addr_q;
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched #(
  parameter int AW      = 16,
  parameter int NSER    = 3,
  parameter int SVC_CYC = 25,
  parameter int TMO_CYC = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trig_in,
  input  logic            bus_exc,
  input  logic [NSER-1:0] ser_req,
  input  logic            cmd_req,
  input  logic            cfg_load,
  input  logic [AW-1:0]   cfg_base,
  input  logic [AW-1:0]   cfg_limit,
  input  logic            bus_ack,
  output logic [AW-1:0]   bus_addr,
  output logic            bus_strb,
  output logic            bus_rw,
  output logic            bus_abort,
  output logic [NSER-1:0] ser_gnt,
  output logic            cmd_gnt,
  output logic            ref_busy,
  output logic            overrun
);
  logic rst_s1, rst_int_n;
  logic fall, ref_go, busy, strb, ack_done;
  logic pend_q, pend_d, ovr_q, ovr_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1    <= 1'b0;
      rst_int_n <= 1'b0;
    end else begin
      rst_s1    <= 1'b1;
      rst_int_n <= rst_s1;
    end
  end

  refsch_sync_edge #(.STAGES(2)) u_edge (
    .clk(clk), .rst_n(rst_int_n), .pin(trig_in), .fall(fall)
  );

  refsch_arb #(.NSER(NSER)) u_arb (
    .en(~busy), .ref_req(pend_q & ~bus_exc), .cmd_req(cmd_req),
    .ser_req(ser_req), .ref_go(ref_go), .cmd_gnt(cmd_gnt), .ser_gnt(ser_gnt)
  );

  refsch_seq #(.SVC_CYC(SVC_CYC), .TMO_CYC(TMO_CYC)) u_seq (
    .clk(clk), .rst_n(rst_int_n), .start(ref_go), .ack(bus_ack),
    .busy(busy), .strb(strb), .ack_done(ack_done), .abort(bus_abort)
  );

  refsch_addr #(.AW(AW)) u_addr (
    .clk(clk), .rst_n(rst_int_n), .load(cfg_load), .base_in(cfg_base),
    .lim_in(cfg_limit), .adv(ack_done), .addr(bus_addr)
  );

  always_comb begin
    pend_d = pend_q;
    if (ref_go)                         pend_d = 1'b0;
    else if (fall && !pend_q && !busy)  pend_d = 1'b1;
    ovr_d = ovr_q;
    if (cfg_load)                       ovr_d = 1'b0;
    else if (fall && (pend_q || busy))  ovr_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      pend_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      ovr_q  <= ovr_d;
    end
  end

  assign ref_busy = busy;
  assign bus_strb = strb;
  assign bus_rw   = strb;
  assign overrun  = ovr_q;
endmodule

// File: rtl/refsch_chk.sv
module refsch_chk #(
  parameter int AW      = 16,
  parameter int NSER    = 3,
  parameter int SVC_CYC = 25
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ref_busy,
  input logic            cmd_gnt,
  input logic [NSER-1:0] ser_gnt,
  input logic            pend,
  input logic            bus_exc,
  input logic            bus_strb,
  input logic            bus_ack,
  input logic            cfg_load,
  input logic [AW-1:0]   bus_addr,
  input logic            bus_abort,
  input logic            overrun
);
  localparam int RW = $clog2(SVC_CYC + 2) + 1;
  logic [RW-1:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        run_len <= '0;
    else if (ref_busy) run_len <= run_len + 1'b1;
    else               run_len <= '0;
  end

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_gnt, ser_gnt})); // R2
  AST_REF_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !bus_exc && !ref_busy) |-> (!cmd_gnt && ser_gnt == '0)); // R2
  AST_EXC_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_exc && !ref_busy) |=> !ref_busy); // R3
  AST_STRB_IN_SVC: assert property (@(posedge clk) disable iff (!rst_n)
    bus_strb |-> ref_busy); // R4
  AST_STRB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_strb && !bus_ack && !bus_abort) |=> bus_strb); // R4
  AST_NO_GNT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ref_busy |-> (!cmd_gnt && ser_gnt == '0)); // R5
  AST_SVC_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    ref_busy |-> (run_len < RW'(SVC_CYC))); // R5
  AST_SVC_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!ref_busy && run_len != '0) |-> (run_len == RW'(SVC_CYC))); // R5
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!(bus_strb && bus_ack) && !cfg_load) |=> $stable(bus_addr)); // R6
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !cfg_load) |=> overrun); // R7
  AST_ABORT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    bus_abort |=> !bus_strb); // R8
endmodule

bind refresh_sched refsch_chk #(.AW(AW), .NSER(NSER), .SVC_CYC(SVC_CYC)) u_chk (
  .clk(clk), .rst_n(rst_int_n), .ref_busy(ref_busy), .cmd_gnt(cmd_gnt),
  .ser_gnt(ser_gnt), .pend(pend_q), .bus_exc(bus_exc), .bus_strb(bus_strb),
  .bus_ack(bus_ack), .cfg_load(cfg_load), .bus_addr(bus_addr),
  .bus_abort(bus_abort), .overrun(overrun)
);

// File: tb/tb_refresh_sched.sv
module tb_refresh_sched;
  localparam int AW = 16;
  localparam int NSER = 3;
  localparam int SVC = 25;
  localparam int TMO = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic trig_in, bus_exc, cmd_req, cfg_load, bus_ack;
  logic [NSER-1:0] ser_req;
  logic [AW-1:0] cfg_base, cfg_limit, bus_addr;
  logic bus_strb, bus_rw, bus_abort, cmd_gnt, ref_busy, overrun;
  logic [NSER-1:0] ser_gnt;

  refresh_sched #(.AW(AW), .NSER(NSER), .SVC_CYC(SVC), .TMO_CYC(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .bus_exc(bus_exc),
    .ser_req(ser_req), .cmd_req(cmd_req), .cfg_load(cfg_load),
    .cfg_base(cfg_base), .cfg_limit(cfg_limit), .bus_ack(bus_ack),
    .bus_addr(bus_addr), .bus_strb(bus_strb), .bus_rw(bus_rw),
    .bus_abort(bus_abort), .ser_gnt(ser_gnt), .cmd_gnt(cmd_gnt),
    .ref_busy(ref_busy), .overrun(overrun)
  );

  always #4 clk = ~clk;

  int nchk = 0, nfail = 0, cyc = 0;
  int nref = 0, nabort = 0, prev_busy = 0;
  int ack_lat = 2;
  bit traffic = 1'b0, arm_coinc = 1'b0, done = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  int trig_q[$];

  // behavioural model state
  int m_rel, m_pend, m_busy, m_cnt, m_strb, m_wcnt, m_addr, m_base, m_lim, m_ovr;

  task automatic cmp(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic model_reset();
    trig_q = '{1, 1, 1};
    m_rel = 0; m_pend = 0; m_busy = 0; m_cnt = 0; m_strb = 0; m_wcnt = 0;
    m_addr = 0; m_base = 0; m_lim = 16'hFFFF; m_ovr = 0;
  endtask

  task automatic step();
    int fall, rwin, ackd, abrt, e_cmd, e_ser;
    int n_pend, n_ovr, n_busy, n_cnt, n_strb, n_wcnt, n_addr;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    ser_req = traffic ? lfsr[2:0] : '0;
    cmd_req = traffic ? (lfsr[5] & lfsr[9]) : 1'b0;
    bus_ack = (m_strb != 0) && (m_wcnt >= ack_lat);
    if (arm_coinc && bus_ack) begin
      cfg_load = 1'b1; cfg_base = 16'h0040; cfg_limit = 16'h007F;
      arm_coinc = 1'b0;
    end
    #1;
    fall = (trig_q[2] == 1 && trig_q[1] == 0);
    rwin = (m_rel >= 2) && !m_busy && m_pend && !bus_exc;
    e_cmd = (!m_busy && !rwin && cmd_req);
    e_ser = 0;
    if (!m_busy && !rwin && !cmd_req) begin
      if (ser_req[0]) e_ser = 1;
      else if (ser_req[1]) e_ser = 2;
      else if (ser_req[2]) e_ser = 4;
    end
    ackd = m_strb && bus_ack;
    abrt = m_strb && !bus_ack && (m_wcnt == TMO - 1);
    cmp("R5 ref_busy", ref_busy, m_busy);
    cmp("R4 bus_strb", bus_strb, m_strb);
    cmp("R4 bus_rw", bus_rw, m_strb);
    cmp("R6 bus_addr", bus_addr, m_addr);
    cmp("R7 overrun", overrun, m_ovr);
    cmp("R8 bus_abort", bus_abort, abrt);
    cmp("R2 cmd_gnt", cmd_gnt, e_cmd);
    cmp("R2 ser_gnt", ser_gnt, e_ser);
    if (ref_busy && !prev_busy) nref++;
    prev_busy = ref_busy;
    if (bus_abort) nabort++;
    if (m_rel < 2) begin
      m_rel++;
    end else begin
      n_pend = m_pend;
      if (rwin) n_pend = 0;
      else if (fall && !m_pend && !m_busy) n_pend = 1;
      n_ovr = cfg_load ? 0 : ((fall && (m_pend || m_busy)) ? 1 : m_ovr);
      n_busy = m_busy; n_cnt = m_cnt; n_strb = m_strb; n_wcnt = m_wcnt;
      if (rwin) begin
        n_busy = 1; n_cnt = 0; n_strb = 1; n_wcnt = 0;
      end else begin
        if (m_busy) begin
          if (m_cnt == SVC - 1) n_busy = 0; else n_cnt = m_cnt + 1;
        end
        if (m_strb) begin
          if (ackd || abrt) n_strb = 0; else n_wcnt = m_wcnt + 1;
        end
      end
      n_addr = m_addr;
      if (cfg_load) begin
        n_addr = cfg_base; m_base = cfg_base; m_lim = cfg_limit;
      end else if (ackd) begin
        n_addr = (m_addr == m_lim) ? m_base : ((m_addr + 1) % 65536);
      end
      m_pend = n_pend; m_ovr = n_ovr; m_busy = n_busy; m_cnt = n_cnt;
      m_strb = n_strb; m_wcnt = n_wcnt; m_addr = n_addr;
      void'(trig_q.pop_back());
      trig_q.push_front(int'(trig_in));
    end
    cyc++;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic load_cfg(int b, int l);
    cfg_load = 1'b1; cfg_base = b[15:0]; cfg_limit = l[15:0];
    step();
  endtask

  task automatic pulse_train(int periods);
    for (int p = 0; p < periods; p++)
      for (int c = 0; c < 260; c++) begin
        trig_in = (c < 130);
        step();
      end
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired actual=%0d expected=finish", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int r0, a0;
    rst_n = 1'b0; trig_in = 1'b1; bus_exc = 1'b0; cmd_req = 1'b0; ser_req = '0;
    cfg_load = 1'b0; cfg_base = '0; cfg_limit = '0; bus_ack = 1'b0;
    model_reset();
    repeat (3) @(negedge clk);
    // R9 reset state
    cmp("R9 reset bus_addr", bus_addr, 0);
    cmp("R9 reset ref_busy", ref_busy, 0);
    cmp("R9 reset strobe", {bus_strb, bus_rw, bus_abort}, 0);
    cmp("R9 reset overrun", overrun, 0);
    cmp("R9 reset grants", {cmd_gnt, ser_gnt}, 0);
    rst_n = 1'b1;
    run(5);

    // R6 configure a small wrapping window
    load_cfg(16'h0010, 16'h0012);
    cmp("R6 load sets base", bus_addr, 16'h0010);

    // R1 R2 R4 periodic triggers with competing traffic
    traffic = 1'b1;
    r0 = nref;
    pulse_train(4);
    cmp("R1 one service per falling edge", nref - r0, 4);
    cmp("R6 wrap limit to base", bus_addr, 16'h0011);

    // R1 rising edge and steady low create nothing
    r0 = nref;
    trig_in = 1'b0; run(20);
    trig_in = 1'b1; run(60);
    cmp("R1 rising edge ignored", nref - r0, 0);

    // R3 exception holds the request
    r0 = nref;
    bus_exc = 1'b1;
    trig_in = 1'b0; run(50);
    cmp("R3 no start during exception", nref - r0, 0);
    bus_exc = 1'b0; run(40);
    cmp("R3 start after exception", nref - r0, 1);
    trig_in = 1'b1; run(5);

    // R7 overrun on a second edge during service
    r0 = nref;
    trig_in = 1'b0; run(10);
    trig_in = 1'b1; run(4);
    trig_in = 1'b0; run(60);
    cmp("R7 overrun set", overrun, 1);
    cmp("R7 extra edge dropped", nref - r0, 1);
    trig_in = 1'b1; run(5);
    load_cfg(16'h0020, 16'h0030);
    cmp("R7 overrun cleared by load", overrun, 0);

    // R8 timeout without acknowledge
    ack_lat = 100;
    a0 = bus_addr; r0 = nabort;
    trig_in = 1'b0; run(40);
    cmp("R8 one abort", nabort - r0, 1);
    cmp("R8 address not advanced", bus_addr, a0);
    ack_lat = 2;
    trig_in = 1'b1; run(5);

    // R6 acknowledge coinciding with a configuration load
    arm_coinc = 1'b1;
    trig_in = 1'b0; run(40);
    cmp("R6 load beats ack", bus_addr, 16'h0040);
    trig_in = 1'b1; run(5);

    // R7 edges swept across the end of a service window
    for (int d = 20; d < 32; d++) begin
      trig_in = 1'b0; run(3);
      trig_in = 1'b1; run(d);
    end
    run(40);
    load_cfg(16'h0000, 16'hFFFF);
    run(5);

    traffic = 1'b0;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule